// File: doc/BRIEF.md
# Transfer Descriptor Fetch Unit

This unit supplies one side (source or destination) of a DMA channel with 16-byte transfer descriptors. It reads a descriptor either straight from a bank of register values or from memory, one 32-bit word per read, at the address held in its current-descriptor pointer. It then unpacks the descriptor into a buffer address, a byte count and a few attribute flags. Memory descriptors are little-endian. The first 8 bytes are the buffer address, the next 4 bytes are the byte count and the last 4 bytes are the attributes.

Each descriptor's type flag decides how the pointer moves on. A linear descriptor bumps the pointer by 16 bytes. A linked descriptor makes the unit read a 64-bit successor pointer stored just past the descriptor. A destination-side unit advances right after each fetch. A source-side unit waits for an explicit advance request, which is issued once the transfer is over, and it refuses to advance past a descriptor whose command is halt. Pointers and buffer addresses are 49 bits wide: a 32-bit low word plus a 17-bit high word whose other bits are dropped.

The parameter `IS_DST` selects the side.

Top module: `dscr_fetch`

## Requirements
- R1: After reset `busy`, `dscr_valid`, `err`, `rd_err` and `rd_req` are 0 and `cur_ptr` is 0.
- R2: A `ptr_load` pulse while idle sets `cur_ptr` to {`start_hi`, `start_lo`} one cycle later and clears `err`.
- R3: With `mem_mode`=0, a `fetch_go` pulse presents the register-bank descriptor one cycle later with `dscr_valid` high for one cycle. No memory read is issued and `cur_ptr` does not change.
- R4: With `mem_mode`=1 and a 16-byte aligned pointer, a fetch issues exactly four single-cycle reads at pointer+0, +4, +8 and +12, in that order, with at most one read outstanding. `dscr_addr` is {bits 16:0 of word 1, word 0} and `dscr_size` is bits 29:0 of word 2.
- R5: Attribute word bit 0 is coherent, bit 1 is type (0 linear, 1 linked), bit 2 is interrupt and bits 4:3 are the command (1 halt, 2 stop). A destination unit always reports command 0.
- R6: A memory fetch from a pointer whose low 4 bits are not zero issues no read. It presents an all-zero descriptor with `dscr_valid`, sets the sticky `err`, pulses `rd_err` in the same cycle, and leaves `cur_ptr` unchanged.
- R7: A destination unit that fetches a linear descriptor sets `cur_ptr` to pointer+16 (modulo 2^49) by the cycle `dscr_valid` rises.
- R8: A destination unit that fetches a linked descriptor reads two more words at pointer+16 and +20. It loads `cur_ptr` with {bits 16:0 of the second word, first word} before raising `dscr_valid`.
- R9: A source unit never moves `cur_ptr` during a fetch. An `adv_go` pulse then adds 16 for a linear descriptor, or reads and loads the successor pointer at +16/+20 for a linked one.
- R10: `adv_go` has no effect when the last source descriptor's command is halt, when `mem_mode` is 0, or on a destination unit.
- R11: `busy` is high from the cycle after an accepted memory fetch until `dscr_valid` rises. `fetch_go` pulses during that time are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mem_mode | input | 1 | 1: descriptors from memory, 0: from register bank |
| ptr_load | input | 1 | Load the pointer from the start inputs |
| start_lo | input | 32 | Start pointer low word |
| start_hi | input | 17 | Start pointer high word |
| fetch_go | input | 1 | Fetch one descriptor |
| adv_go | input | 1 | Advance the pointer past the last descriptor (source only) |
| reg_addr_lo | input | 32 | Register-bank buffer address, low word |
| reg_addr_hi | input | 17 | Register-bank buffer address, high word |
| reg_size | input | 30 | Register-bank byte count |
| reg_attr | input | 5 | Register-bank attributes, same layout as R5 |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | 49 | Read byte address |
| rd_rvalid | input | 1 | Read data valid |
| rd_rdata | input | 32 | Read data |
| busy | output | 1 | Memory fetch or advance in progress |
| dscr_valid | output | 1 | Descriptor outputs updated (one-cycle pulse) |
| dscr_addr | output | 49 | Buffer address |
| dscr_size | output | 30 | Byte count |
| dscr_intr | output | 1 | Interrupt-on-completion flag |
| dscr_type | output | 1 | 0 linear, 1 linked |
| dscr_coh | output | 1 | Coherent flag |
| dscr_cmd | output | 2 | Command (source only) |
| err | output | 1 | Sticky misalignment error |
| rd_err | output | 1 | Descriptor read-error event pulse |
| cur_ptr | output | 49 | Current-descriptor pointer |

## Verification
One source unit and one destination unit run against a shared word memory whose read latency varies from one to three cycles. All 32 attribute codes are swept in register mode, which shows that each field is unpacked from its own bit and that the destination masks the command. Every type, interrupt and coherence combination is swept in memory mode, which separates the linear bump from the linked reload and checks the request address order. Every misalignment offset from 1 to 15 is swept to show that no read leaves the unit. Pointers sitting on a 32-bit carry and on the 49-bit wrap check the adder width. The source sweep over all four commands separates halt from the other commands.

// File: rtl/dscr_fetch.sv
module dscr_fetch #(
  parameter bit IS_DST = 1'b0,
  parameter int HW = 17,
  parameter int SW = 30
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mem_mode,
  input  logic           ptr_load,
  input  logic [31:0]    start_lo,
  input  logic [HW-1:0]  start_hi,
  input  logic           fetch_go,
  input  logic           adv_go,
  input  logic [31:0]    reg_addr_lo,
  input  logic [HW-1:0]  reg_addr_hi,
  input  logic [SW-1:0]  reg_size,
  input  logic [4:0]     reg_attr,
  output logic           rd_req,
  output logic [HW+31:0] rd_addr,
  input  logic           rd_rvalid,
  input  logic [31:0]    rd_rdata,
  output logic           busy,
  output logic           dscr_valid,
  output logic [HW+31:0] dscr_addr,
  output logic [SW-1:0]  dscr_size,
  output logic           dscr_intr,
  output logic           dscr_type,
  output logic           dscr_coh,
  output logic [1:0]     dscr_cmd,
  output logic           err,
  output logic           rd_err,
  output logic [HW+31:0] cur_ptr
);
  localparam int AW = HW + 32;
  localparam logic [1:0] CMD_HALT = 2'd1;

  typedef enum logic [1:0] {S_IDLE, S_DSC, S_NXT} st_t;

  st_t         state;
  logic [1:0]  idx;
  logic        pend;
  logic [31:0] nxt_lo;
  logic        take;

  assign busy    = (state != S_IDLE);
  assign rd_req  = busy && !pend;
  assign rd_addr = cur_ptr + {{(HW+27){1'b0}}, (state == S_NXT), idx, 2'b00};
  assign take    = rd_rvalid && pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      idx        <= '0;
      pend       <= 1'b0;
      nxt_lo     <= '0;
      cur_ptr    <= '0;
      dscr_valid <= 1'b0;
      dscr_addr  <= '0;
      dscr_size  <= '0;
      dscr_intr  <= 1'b0;
      dscr_type  <= 1'b0;
      dscr_coh   <= 1'b0;
      dscr_cmd   <= '0;
      err        <= 1'b0;
      rd_err     <= 1'b0;
    end else begin
      dscr_valid <= 1'b0;
      rd_err     <= 1'b0;
      case (state)
        S_IDLE: begin
          if (ptr_load) begin
            cur_ptr <= {start_hi, start_lo};
            err     <= 1'b0;
          end else if (fetch_go) begin
            if (!mem_mode) begin
              dscr_addr  <= {reg_addr_hi, reg_addr_lo};
              dscr_size  <= reg_size;
              dscr_coh   <= reg_attr[0];
              dscr_type  <= reg_attr[1];
              dscr_intr  <= reg_attr[2];
              dscr_cmd   <= IS_DST ? 2'd0 : reg_attr[4:3];
              dscr_valid <= 1'b1;
            end else if (cur_ptr[3:0] != 4'd0) begin
              dscr_addr  <= '0;
              dscr_size  <= '0;
              dscr_coh   <= 1'b0;
              dscr_type  <= 1'b0;
              dscr_intr  <= 1'b0;
              dscr_cmd   <= '0;
              err        <= 1'b1;
              rd_err     <= 1'b1;
              dscr_valid <= 1'b1;
            end else begin
              state <= S_DSC;
              idx   <= '0;
              pend  <= 1'b0;
            end
          end else if (adv_go && !IS_DST && mem_mode && dscr_cmd != CMD_HALT) begin
            if (dscr_type) begin
              state <= S_NXT;
              idx   <= '0;
              pend  <= 1'b0;
            end else begin
              cur_ptr <= cur_ptr + AW'(16);
            end
          end
        end
        S_DSC: begin
          if (rd_req) begin
            pend <= 1'b1;
          end else if (take) begin
            pend <= 1'b0;
            idx  <= idx + 2'd1;
            case (idx)
              2'd0: dscr_addr[31:0] <= rd_rdata;
              2'd1: dscr_addr[AW-1:32] <= rd_rdata[HW-1:0];
              2'd2: dscr_size <= rd_rdata[SW-1:0];
              default: begin
                dscr_coh  <= rd_rdata[0];
                dscr_type <= rd_rdata[1];
                dscr_intr <= rd_rdata[2];
                dscr_cmd  <= IS_DST ? 2'd0 : rd_rdata[4:3];
                if (IS_DST && rd_rdata[1]) begin
                  state <= S_NXT;
                  idx   <= '0;
                end else begin
                  if (IS_DST) cur_ptr <= cur_ptr + AW'(16);
                  state      <= S_IDLE;
                  dscr_valid <= 1'b1;
                end
              end
            endcase
          end
        end
        S_NXT: begin
          if (rd_req) begin
            pend <= 1'b1;
          end else if (take) begin
            pend <= 1'b0;
            idx  <= idx + 2'd1;
            if (idx == 2'd0) begin
              nxt_lo <= rd_rdata;
            end else begin
              cur_ptr    <= {rd_rdata[HW-1:0], nxt_lo};
              state      <= S_IDLE;
              dscr_valid <= IS_DST;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_req_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);
  p_req_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (rd_addr[1:0] == 2'b00 && busy));
  p_err_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> (dscr_valid && err && dscr_addr == '0 && dscr_size == '0 &&
                !dscr_type && !dscr_intr && !dscr_coh && dscr_cmd == 2'd0));
  p_valid_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dscr_valid |-> !busy);
  p_ptr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !ptr_load && !adv_go) |=> $stable(cur_ptr));
endmodule

// File: tb/dscr_fetch_bench.sv
module dscr_fetch_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        mem_mode = 1'b0;
  logic [31:0] reg_addr_lo = '0;
  logic [16:0] reg_addr_hi = '0;
  logic [29:0] reg_size = '0;
  logic [4:0]  reg_attr = '0;

  logic        ptr_load [2];
  logic [31:0] start_lo [2];
  logic [16:0] start_hi [2];
  logic        fetch_go [2];
  logic        adv_go   [2];
  logic        rd_req   [2];
  logic [48:0] rd_addr  [2];
  logic        rvalid   [2];
  logic [31:0] rdata    [2];
  logic        busy     [2];
  logic        dv       [2];
  logic [48:0] daddr    [2];
  logic [29:0] dsize    [2];
  logic        dintr [2], dtype [2], dcoh [2];
  logic [1:0]  dcmd     [2];
  logic        err      [2];
  logic        rerr     [2];
  logic [48:0] cptr     [2];

  dscr_fetch #(.IS_DST(1'b0)) u_dscr_fetch (
    .clk(clk), .rst_n(rst_n), .mem_mode(mem_mode), .ptr_load(ptr_load[0]),
    .start_lo(start_lo[0]), .start_hi(start_hi[0]), .fetch_go(fetch_go[0]),
    .adv_go(adv_go[0]), .reg_addr_lo(reg_addr_lo), .reg_addr_hi(reg_addr_hi),
    .reg_size(reg_size), .reg_attr(reg_attr), .rd_req(rd_req[0]),
    .rd_addr(rd_addr[0]), .rd_rvalid(rvalid[0]), .rd_rdata(rdata[0]),
    .busy(busy[0]), .dscr_valid(dv[0]), .dscr_addr(daddr[0]),
    .dscr_size(dsize[0]), .dscr_intr(dintr[0]), .dscr_type(dtype[0]),
    .dscr_coh(dcoh[0]), .dscr_cmd(dcmd[0]), .err(err[0]), .rd_err(rerr[0]),
    .cur_ptr(cptr[0]));

  dscr_fetch #(.IS_DST(1'b1)) u_dscr_fetch_dst (
    .clk(clk), .rst_n(rst_n), .mem_mode(mem_mode), .ptr_load(ptr_load[1]),
    .start_lo(start_lo[1]), .start_hi(start_hi[1]), .fetch_go(fetch_go[1]),
    .adv_go(adv_go[1]), .reg_addr_lo(reg_addr_lo), .reg_addr_hi(reg_addr_hi),
    .reg_size(reg_size), .reg_attr(reg_attr), .rd_req(rd_req[1]),
    .rd_addr(rd_addr[1]), .rd_rvalid(rvalid[1]), .rd_rdata(rdata[1]),
    .busy(busy[1]), .dscr_valid(dv[1]), .dscr_addr(daddr[1]),
    .dscr_size(dsize[1]), .dscr_intr(dintr[1]), .dscr_type(dtype[1]),
    .dscr_coh(dcoh[1]), .dscr_cmd(dcmd[1]), .err(err[1]), .rd_err(rerr[1]),
    .cur_ptr(cptr[1]));

  logic [31:0] mem [64];
  int lat = 1;
  int cnt [2];
  logic [48:0] raddr [2];
  logic [48:0] req_log [2][8];
  int nreq [2];
  int n_tests = 0;
  int n_fail = 0;

  always @(negedge clk) begin
    for (int s = 0; s < 2; s++) begin
      rvalid[s] = 1'b0;
      if (cnt[s] > 0) begin
        cnt[s] = cnt[s] - 1;
        if (cnt[s] == 0) begin
          rvalid[s] = 1'b1;
          rdata[s]  = mem[raddr[s][7:2]];
        end
      end
      if (rd_req[s]) begin
        cnt[s]   = lat;
        raddr[s] = rd_addr[s];
        if (nreq[s] < 8) req_log[s][nreq[s]] = rd_addr[s];
        nreq[s] = nreq[s] + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic put_dsc(input logic [7:0] a, input logic [48:0] ba, input logic [29:0] sz,
                         input logic [4:0] at);
    mem[a[7:2]]       = ba[31:0];
    mem[a[7:2] + 6'd1] = {15'h5A5A, ba[48:32]};
    mem[a[7:2] + 6'd2] = {2'b11, sz};
    mem[a[7:2] + 6'd3] = {27'h7FF_FFFF, at};
  endtask

  task automatic put_nxt(input logic [7:0] a, input logic [48:0] np);
    mem[a[7:2] + 6'd4] = np[31:0];
    mem[a[7:2] + 6'd5] = {15'h7E5A, np[48:32]};
  endtask

  task automatic load(input int s, input logic [48:0] p);
    start_lo[s] = p[31:0];
    start_hi[s] = p[48:32];
    ptr_load[s] = 1'b1;
    @(negedge clk);
    ptr_load[s] = 1'b0;
  endtask

  task automatic fetch(input int s, input bit mm, output bit saw_busy);
    nreq[s] = 0;
    mem_mode = mm;
    fetch_go[s] = 1'b1;
    @(negedge clk);
    fetch_go[s] = 1'b0;
    saw_busy = busy[s];
    for (int i = 0; i < 100 && !dv[s]; i++) @(negedge clk);
    chk("R11 valid pulse reached", {63'd0, dv[s]}, 64'd1);
    chk("R11 idle at valid", {63'd0, busy[s]}, 64'd0);
  endtask

  task automatic adv(input int s);
    nreq[s] = 0;
    adv_go[s] = 1'b1;
    @(negedge clk);
    adv_go[s] = 1'b0;
    for (int i = 0; i < 100 && busy[s]; i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    bit sb;
    logic [48:0] p, np, ba;
    logic [4:0] at;
    for (int s = 0; s < 2; s++) begin
      ptr_load[s] = 0; start_lo[s] = 0; start_hi[s] = 0; fetch_go[s] = 0;
      adv_go[s] = 0; rvalid[s] = 0; rdata[s] = 0; cnt[s] = 0; nreq[s] = 0;
    end
    for (int i = 0; i < 64; i++) mem[i] = 32'hDEAD_0000 + i;
    repeat (3) @(negedge clk);
    for (int s = 0; s < 2; s++) begin
      chk("R1 busy", {63'd0, busy[s]}, 0);
      chk("R1 valid", {63'd0, dv[s]}, 0);
      chk("R1 err", {63'd0, err[s] | rerr[s]}, 0);
      chk("R1 rd_req", {63'd0, rd_req[s]}, 0);
      chk("R1 ptr", {15'd0, cptr[s]}, 0);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R2 pointer load
    for (int s = 0; s < 2; s++) begin
      p = {17'h1ABCD, 32'h8765_4320};
      load(s, p);
      chk("R2 ptr load", {15'd0, cptr[s]}, {15'd0, p});
    end

    // R3 / R5 register-bank sweep of all attribute codes
    for (int r = 0; r < 32; r++) begin
      reg_addr_lo = 32'h1000_0000 + r * 7;
      reg_addr_hi = 17'h10000 | 17'(r);
      reg_size    = 30'h3FFF_FFFF - 30'(r);
      reg_attr    = 5'(r);
      for (int s = 0; s < 2; s++) begin
        fetch(s, 1'b0, sb);
        chk("R3 no busy", {63'd0, sb}, 0);
        chk("R3 no read", nreq[s], 0);
        chk("R3 addr", {15'd0, daddr[s]}, {15'd0, reg_addr_hi, reg_addr_lo});
        chk("R3 size", {34'd0, dsize[s]}, {34'd0, reg_size});
        chk("R5 coh", {63'd0, dcoh[s]}, r & 1);
        chk("R5 type", {63'd0, dtype[s]}, (r >> 1) & 1);
        chk("R5 intr", {63'd0, dintr[s]}, (r >> 2) & 1);
        chk("R5 cmd", {62'd0, dcmd[s]}, s ? 0 : (r >> 3) & 3);
        chk("R3 ptr kept", {15'd0, cptr[s]}, {15'd0, 17'h1ABCD, 32'h8765_4320});
      end
    end

    // R4 / R7 / R8 destination memory sweep
    for (int t = 0; t < 8; t++) begin
      lat = 1 + (t % 3);
      at  = {2'b11, t[2:0]};
      ba  = {17'(17'h0F00 + t), 32'hA000_0000 | 32'(t * 3)};
      np  = {17'h1_2345, 32'hCAFE_0000 + 32'(t * 16)};
      put_dsc(8'(t * 32), ba, 30'h100 + 30'(t), at);
      put_nxt(8'(t * 32), np);
      p = {17'h1ABCD, 32'h1234_5600 | 32'(t * 32)};
      load(1, p);
      fetch(1, 1'b1, sb);
      chk("R11 busy during fetch", {63'd0, sb}, 1);
      chk("R4 addr", {15'd0, daddr[1]}, {15'd0, ba});
      chk("R4 size", {34'd0, dsize[1]}, 64'h100 + t);
      chk("R5 dst fields", {60'd0, dintr[1], dtype[1], dcoh[1], 1'b0}, {60'd0, at[2:0], 1'b0});
      chk("R5 dst cmd zero", {62'd0, dcmd[1]}, 0);
      chk("R4 read count", nreq[1], at[1] ? 6 : 4);
      for (int k = 0; k < 4; k++)
        chk("R4 read order", {15'd0, req_log[1][k]}, {15'd0, p + 49'(4 * k)});
      if (at[1]) begin
        chk("R8 next lo read", {15'd0, req_log[1][4]}, {15'd0, p + 49'd16});
        chk("R8 next hi read", {15'd0, req_log[1][5]}, {15'd0, p + 49'd20});
        chk("R8 dst linked ptr", {15'd0, cptr[1]}, {15'd0, np});
      end else begin
        chk("R7 dst linear ptr", {15'd0, cptr[1]}, {15'd0, p + 49'd16});
      end
    end

    // R7 carry and wrap of the 49-bit pointer
    lat = 2;
    put_dsc(8'hF0, 49'h1_2222_3333_4444 & 49'h1_FFFF_FFFF_FFFF, 30'd9, 5'b00000);
    load(1, {17'h00005, 32'hFFFF_FFF0});
    fetch(1, 1'b1, sb);
    chk("R7 carry into high word", {15'd0, cptr[1]}, {15'd0, 17'h00006, 32'h0});
    load(1, 49'h1_FFFF_FFFF_FFF0);
    fetch(1, 1'b1, sb);
    chk("R7 wrap to zero", {15'd0, cptr[1]}, 0);

    // R11 fetch_go ignored while busy
    lat = 3;
    load(1, {17'h0, 32'h0000_00F0});
    nreq[1] = 0;
    fetch_go[1] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R11 busy", {63'd0, busy[1]}, 1);
    for (int i = 0; i < 100 && !dv[1]; i++) @(negedge clk);
    fetch_go[1] = 1'b0;
    @(negedge clk);
    chk("R11 extra go ignored: reads", nreq[1], 4);
    chk("R11 extra go ignored: idle", {63'd0, busy[1]}, 0);

    // R6 misalignment sweep, both sides
    for (int s = 0; s < 2; s++) begin
      for (int off = 1; off < 16; off++) begin
        p = {17'h00333, 32'h0000_0040 + 32'(off)};
        load(s, p);
        chk("R2 err cleared", {63'd0, err[s]}, 0);
        fetch(s, 1'b1, sb);
        chk("R6 no read", nreq[s], 0);
        chk("R6 event", {63'd0, rerr[s]}, 1);
        chk("R6 zero descr", {15'd0, daddr[s]} | {34'd0, dsize[s]} |
            {59'd0, dcmd[s], dintr[s], dtype[s], dcoh[s]}, 0);
        chk("R6 ptr kept", {15'd0, cptr[s]}, {15'd0, p});
        @(negedge clk);
        chk("R6 err sticky", {63'd0, err[s]}, 1);
        chk("R6 event one cycle", {63'd0, rerr[s]}, 0);
      end
    end

    // R9 / R10 source sweep over type and command
    for (int k = 0; k < 8; k++) begin
      lat = 1 + (k % 2);
      at  = {k[2:1], k[0] ^ k[1], k[0], k[2]};
      ba  = {17'h00F0F, 32'h5500_0000 + 32'(k)};
      np  = {17'h0_0777, 32'hBEE0_0000 + 32'(k * 16)};
      put_dsc(8'(k * 32), ba, 30'h3000 + 30'(k), at);
      put_nxt(8'(k * 32), np);
      p = {17'h00F0F, 32'h0000_1000 | 32'(k * 32)};
      load(0, p);
      fetch(0, 1'b1, sb);
      chk("R9 fetch keeps ptr", {15'd0, cptr[0]}, {15'd0, p});
      chk("R5 src cmd", {62'd0, dcmd[0]}, k >> 1);
      chk("R5 src type", {63'd0, dtype[0]}, k & 1);
      chk("R4 src addr", {15'd0, daddr[0]}, {15'd0, ba});
      adv(0);
      if (at[4:3] == 2'd1) begin
        chk("R10 halt blocks advance", {15'd0, cptr[0]}, {15'd0, p});
        chk("R10 halt no read", nreq[0], 0);
      end else if (at[1]) begin
        chk("R9 src linked ptr", {15'd0, cptr[0]}, {15'd0, np});
        chk("R9 src next reads", {15'd0, req_log[0][0]} ^ {15'd0, req_log[0][1]},
            {15'd0, (p + 49'd16) ^ (p + 49'd20)});
      end else begin
        chk("R9 src linear ptr", {15'd0, cptr[0]}, {15'd0, p + 49'd16});
      end
    end

    // R10 advance ignored in register mode and on destination
    put_dsc(8'h00, 49'h0, 30'd1, 5'b00000);
    load(0, 49'h0_0000_0200);
    fetch(0, 1'b1, sb);
    mem_mode = 1'b0;
    adv(0);
    chk("R10 register mode advance ignored", {15'd0, cptr[0]}, 64'h200);
    mem_mode = 1'b1;
    load(1, 49'h0_0000_0300);
    adv(1);
    chk("R10 dst advance ignored", {15'd0, cptr[1]}, 64'h300);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule